// File: doc/BRIEF.md
# Self-Synchronizing Pseudo-Random Pattern Checker

This block sits behind a deserializer and checks each 40-bit parallel word against one of four pseudo-random bit sequences of order 7, 15, 23 or 31. It needs no word aligner. While it hunts for the sequence, each expected word is predicted from the previous received word. The predictor needs only the most recent 31 bits of history, so any bit phase of the incoming stream is accepted. Once enough clean words have been seen, the prediction is taken from the block's own previous expected word. From then on, bit errors on the line cannot disturb the reference.

For every word the block gives the bitwise difference between received and expected data, a flag that any bit differs, and the number of differing bits. It also gives a tracking status and a one-cycle pulse when tracking is lost. Two saturating totals, errored bits and checked words, accumulate only while the block is tracking. A receive-side link reset sends the checker back to hunting without clearing these totals.

Top module: `prbs_sync_checker`

## Requirements
- R1: `pat_sel_i` picks the sequence: 0 = x^7+x^6+1, 1 = x^15+x^14+1, 2 = x^23+x^18+1, 3 = x^31+x^28+1. Bit 0 of a word is the earliest bit in time. The recurrence is s[t] = s[t-n] xor s[t-m]. A stream of one order never brings the checker to tracking when another order is selected.
- R2: While hunting, the expected word is computed from the previously received word, so lock is reached at any bit phase.
- R3: After a full reset with a valid stream applied from the first word, `lock_o` is low after the 16th word and high after the 17th word (16 consecutive clean words).
- R4: While tracking, a corrupted word shows errors only in that word. The next uncorrupted word compares clean.
- R5: One cycle after a word is presented, `err_word_o` holds received XOR expected, `err_bits_o` holds its count of ones, and `err_flag_o` is high exactly when that count is nonzero.
- R6: While tracking, 8 consecutive words each with more than 10 errored bits end tracking, and `lock_lost_o` pulses high for one cycle. A word with 10 or fewer errored bits restarts that run.
- R7: `rx_link_rst_i` high for a cycle returns the checker to hunting at the next edge and leaves both totals unchanged. The word presented during that cycle seeds the prediction, so 16 further clean words restore tracking.
- R8: `pat_sel_i` is taken only while hunting. Changing it while tracking has no effect on the comparison.
- R9: While tracking, `err_cnt_o` adds each word's errored-bit count and saturates at all ones. `word_cnt_o` counts each checked word and also saturates. Neither total changes while hunting.
- R10: During reset all outputs are zero and `lock_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_link_rst_i | input | 1 | Receive-side link reset, returns checker to hunting |
| pat_sel_i | input | 2 | Sequence order select |
| rx_data_i | input | DATA_W | Received parallel word |
| err_word_o | output | DATA_W | Received XOR expected, registered |
| err_flag_o | output | 1 | Word contained at least one error |
| err_bits_o | output | BITS_W | Errored-bit count of the word |
| lock_o | output | 1 | Checker is tracking |
| lock_lost_o | output | 1 | One-cycle pulse on loss of tracking |
| err_cnt_o | output | CNT_W | Saturating errored-bit total |
| word_cnt_o | output | CNT_W | Saturating checked-word total |

## Verification
Several properties hold on every cycle and are checked continuously. The bit count matches the ones in the difference word, and the flag agrees with the count. Tracking only begins on a clean word. The loss pulse is single and only follows tracking. A link reset always clears tracking. The totals never decrease and stay still while hunting. Other behaviour can only be shown by the bench's scenarios with a known stream and phase. These are acquisition at arbitrary phases, the exact 16-word lock point, immunity of the reference to injected errors, rejection of a wrong order, the 10/11-bit threshold, and ignoring a select change while tracking.

// File: rtl/prbs_sync_pkg.sv
`timescale 1ns/1ps
package prbs_sync_pkg;

   typedef enum logic [1:0] {
      PAT_O7  = 2'd0,
      PAT_O15 = 2'd1,
      PAT_O23 = 2'd2,
      PAT_O31 = 2'd3
   } pat_e;

   typedef enum logic {
      ST_HUNT  = 1'b0,
      ST_TRACK = 1'b1
   } trk_e;

   localparam int NUM_PAT   = 4;
   localparam int MAX_ORDER = 31;

   // long tap (order) of each selectable polynomial
   function automatic int tap_long(input int idx);
      case (idx)
         0:       return 7;
         1:       return 15;
         2:       return 23;
         default: return 31;
      endcase
   endfunction

   // short tap of each selectable polynomial
   function automatic int tap_short(input int idx);
      case (idx)
         0:       return 6;
         1:       return 14;
         2:       return 18;
         default: return 28;
      endcase
   endfunction

endpackage

// File: rtl/prbs_sync_predict.sv
`timescale 1ns/1ps
module prbs_sync_predict
   import prbs_sync_pkg::*;
#(
   parameter int DATA_W = 40
) (
   input  pat_e              sel_i,
   input  logic [DATA_W-1:0] base_i,
   output logic [DATA_W-1:0] next_o
);

   logic [DATA_W-1:0] cand [NUM_PAT];

   // one parallel next-word generator per order; bit i of a word is later than bit i-1
   for (genvar g = 0; g < NUM_PAT; g++) begin : g_order
      localparam int TN = tap_long(g);
      localparam int TM = tap_short(g);
      logic [2*DATA_W-1:0] ext;

      always_comb begin
         ext = '0;
         ext[DATA_W-1:0] = base_i;
         for (int i = 0; i < DATA_W; i++) begin
            ext[DATA_W+i] = ext[DATA_W+i-TN] ^ ext[DATA_W+i-TM];
         end
      end

      assign cand[g] = ext[2*DATA_W-1:DATA_W];
   end

   assign next_o = cand[sel_i];

endmodule

// File: rtl/prbs_sync_popcount.sv
`timescale 1ns/1ps
module prbs_sync_popcount #(
   parameter int W     = 40,
   parameter int OUT_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     vec_i,
   output logic [OUT_W-1:0] ones_o
);

   localparam int CHUNK = 8;
   localparam int NCH   = (W + CHUNK - 1) / CHUNK;
   localparam int PW    = $clog2(CHUNK + 1);

   logic [NCH*CHUNK-1:0] padded;
   logic [PW-1:0]        part [NCH];

   assign padded = (NCH*CHUNK)'(vec_i);

   // first level: count each byte-sized slice
   for (genvar g = 0; g < NCH; g++) begin : g_slice
      logic [PW-1:0] cnt;
      always_comb begin
         cnt = '0;
         for (int b = 0; b < CHUNK; b++) begin
            cnt = cnt + PW'(padded[g*CHUNK+b]);
         end
      end
      assign part[g] = cnt;
   end

   // second level: sum the slices
   always_comb begin
      ones_o = '0;
      for (int k = 0; k < NCH; k++) begin
         ones_o = ones_o + OUT_W'(part[k]);
      end
   end

endmodule

// File: rtl/prbs_sync_lockfsm.sv
`timescale 1ns/1ps
module prbs_sync_lockfsm
   import prbs_sync_pkg::*;
#(
   parameter int LOCK_RUN = 16,
   parameter int LOSS_RUN = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic link_rst_i,
   input  logic clean_i,
   input  logic bad_i,
   output logic locked_o,
   output logic lost_o
);

   localparam int GW = $clog2(LOCK_RUN + 1);
   localparam int BW = $clog2(LOSS_RUN + 1);

   if (LOCK_RUN < 1 || LOSS_RUN < 1) begin : g_bad_run
      $error("run lengths must be at least one");
   end

   trk_e          st_q;
   logic [GW-1:0] good_q;
   logic [BW-1:0] bad_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_HUNT;
         good_q <= '0;
         bad_q  <= '0;
         lost_o <= 1'b0;
      end else begin
         lost_o <= 1'b0;
         if (link_rst_i) begin
            st_q   <= ST_HUNT;
            good_q <= '0;
            bad_q  <= '0;
         end else if (st_q == ST_HUNT) begin
            bad_q <= '0;
            if (!clean_i) begin
               good_q <= '0;
            end else if (good_q == GW'(LOCK_RUN - 1)) begin
               st_q   <= ST_TRACK;
               good_q <= '0;
            end else begin
               good_q <= good_q + 1'b1;
            end
         end else begin
            good_q <= '0;
            if (!bad_i) begin
               bad_q <= '0;
            end else if (bad_q == BW'(LOSS_RUN - 1)) begin
               st_q   <= ST_HUNT;
               bad_q  <= '0;
               lost_o <= 1'b1;
            end else begin
               bad_q <= bad_q + 1'b1;
            end
         end
      end
   end

   assign locked_o = (st_q == ST_TRACK);

endmodule

// File: rtl/prbs_sync_checker.sv
`timescale 1ns/1ps
module prbs_sync_checker
   import prbs_sync_pkg::*;
#(
   parameter int DATA_W   = 40,
   parameter int LOCK_RUN = 16,
   parameter int LOSS_RUN = 8,
   parameter int BAD_BITS = 10,
   parameter int CNT_W    = 48,
   parameter int BITS_W   = $clog2(DATA_W + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rx_link_rst_i,
   input  logic [1:0]        pat_sel_i,
   input  logic [DATA_W-1:0] rx_data_i,
   output logic [DATA_W-1:0] err_word_o,
   output logic              err_flag_o,
   output logic [BITS_W-1:0] err_bits_o,
   output logic              lock_o,
   output logic              lock_lost_o,
   output logic [CNT_W-1:0]  err_cnt_o,
   output logic [CNT_W-1:0]  word_cnt_o
);

   // elaboration-time parameter checks
   if (DATA_W < MAX_ORDER) begin : g_bad_width
      $error("DATA_W must cover the longest polynomial order");
   end
   if (BITS_W != $clog2(DATA_W + 1)) begin : g_bad_bits
      $error("BITS_W must equal clog2(DATA_W+1)");
   end
   if (CNT_W < BITS_W) begin : g_bad_cnt
      $error("CNT_W narrower than one word's error count");
   end
   if (BAD_BITS < 0 || BAD_BITS >= DATA_W) begin : g_bad_thr
      $error("BAD_BITS out of range");
   end

   pat_e              sel_q;
   logic [DATA_W-1:0] ref_q;
   logic [DATA_W-1:0] expect_w;
   logic [DATA_W-1:0] diff_w;
   logic [BITS_W-1:0] ones_w;
   logic              clean_w;
   logic              bad_w;
   logic              locked_w;
   logic              lost_w;
   logic [CNT_W:0]    err_sum_w;
   logic [CNT_W:0]    word_sum_w;

   // pattern select is taken only while hunting
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= PAT_O7;
      end else if (!locked_w) begin
         sel_q <= pat_e'(pat_sel_i);
      end
   end

   prbs_sync_predict #(
      .DATA_W (DATA_W)
   ) u_predict (
      .sel_i  (sel_q),
      .base_i (ref_q),
      .next_o (expect_w)
   );

   assign diff_w = rx_data_i ^ expect_w;

   prbs_sync_popcount #(
      .W     (DATA_W),
      .OUT_W (BITS_W)
   ) u_popcount (
      .vec_i  (diff_w),
      .ones_o (ones_w)
   );

   assign clean_w = (ones_w == '0);
   assign bad_w   = (ones_w > BITS_W'(BAD_BITS));

   prbs_sync_lockfsm #(
      .LOCK_RUN (LOCK_RUN),
      .LOSS_RUN (LOSS_RUN)
   ) u_lockfsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .link_rst_i (rx_link_rst_i),
      .clean_i    (clean_w),
      .bad_i      (bad_w),
      .locked_o   (locked_w),
      .lost_o     (lost_w)
   );

   // reference: received word while hunting, own prediction while tracking
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q <= '0;
      end else if (rx_link_rst_i || !locked_w) begin
         ref_q <= rx_data_i;
      end else begin
         ref_q <= expect_w;
      end
   end

   // per-word result registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_word_o <= '0;
         err_bits_o <= '0;
         err_flag_o <= 1'b0;
      end else begin
         err_word_o <= diff_w;
         err_bits_o <= ones_w;
         err_flag_o <= !clean_w;
      end
   end

   assign err_sum_w  = {1'b0, err_cnt_o}  + (CNT_W+1)'(ones_w);
   assign word_sum_w = {1'b0, word_cnt_o} + (CNT_W+1)'(1);

   // saturating totals, advanced only for words checked while tracking
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_cnt_o  <= '0;
         word_cnt_o <= '0;
      end else if (locked_w && !rx_link_rst_i) begin
         err_cnt_o  <= err_sum_w[CNT_W]  ? '1 : err_sum_w[CNT_W-1:0];
         word_cnt_o <= word_sum_w[CNT_W] ? '1 : word_sum_w[CNT_W-1:0];
      end
   end

   assign lock_o      = locked_w;
   assign lock_lost_o = lost_w;

endmodule

// File: rtl/prbs_sync_checker_sva.sv
`timescale 1ns/1ps
module prbs_sync_checker_sva #(
   parameter int DATA_W = 40,
   parameter int BITS_W = 6,
   parameter int CNT_W  = 48
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              rx_link_rst_i,
   input logic              lock_o,
   input logic              lock_lost_o,
   input logic              err_flag_o,
   input logic [DATA_W-1:0] err_word_o,
   input logic [BITS_W-1:0] err_bits_o,
   input logic [CNT_W-1:0]  err_cnt_o,
   input logic [CNT_W-1:0]  word_cnt_o
);

   p_clean_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_o) |-> !err_flag_o);

   p_flag_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_flag_o == (err_bits_o != '0));

   p_popcount_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(err_bits_o) == $countones(err_word_o));

   p_lost_from_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_lost_o |-> (!lock_o && $past(lock_o)));

   p_lost_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_lost_o |=> !lock_lost_o);

   p_link_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_link_rst_i |=> (!lock_o && !lock_lost_o));

   p_err_mono_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (err_cnt_o >= $past(err_cnt_o)));

   p_hold_hunt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lock_o |=> ($stable(word_cnt_o) && $stable(err_cnt_o)));

endmodule

bind prbs_sync_checker prbs_sync_checker_sva #(
   .DATA_W (DATA_W),
   .BITS_W (BITS_W),
   .CNT_W  (CNT_W)
) u_sva (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .rx_link_rst_i (rx_link_rst_i),
   .lock_o        (lock_o),
   .lock_lost_o   (lock_lost_o),
   .err_flag_o    (err_flag_o),
   .err_word_o    (err_word_o),
   .err_bits_o    (err_bits_o),
   .err_cnt_o     (err_cnt_o),
   .word_cnt_o    (word_cnt_o)
);

// File: tb/prbs_sync_checker_tb.sv
`timescale 1ns/1ps
module prbs_sync_checker_tb;

   localparam int DW = 40;
   localparam int CW = 16;
   localparam int BW = 6;

   // vector fields: {sel[13:12], phase[11:6], flips[5:0]}
   localparam logic [13:0] VECS [6] = '{
      {2'd0, 6'd3,  6'd1},
      {2'd1, 6'd17, 6'd5},
      {2'd2, 6'd0,  6'd11},
      {2'd3, 6'd29, 6'd40},
      {2'd3, 6'd5,  6'd0},
      {2'd1, 6'd38, 6'd2}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          link_rst;
   logic [1:0]    pat_sel;
   logic [DW-1:0] rx_data;
   logic [DW-1:0] err_word;
   logic          err_flag;
   logic [BW-1:0] err_bits;
   logic          lock;
   logic          lost;
   logic [CW-1:0] err_cnt;
   logic [CW-1:0] word_cnt;

   int            n_chk  = 0;
   int            n_fail = 0;
   bit            done   = 1'b0;
   logic [63:0]   hist;
   int            tap_n;
   int            tap_m;
   logic [CW-1:0] exp_words;
   logic [CW-1:0] exp_errs;

   always #5 clk = ~clk;

   prbs_sync_checker #(
      .CNT_W (CW)
   ) u_dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .rx_link_rst_i (link_rst),
      .pat_sel_i     (pat_sel),
      .rx_data_i     (rx_data),
      .err_word_o    (err_word),
      .err_flag_o    (err_flag),
      .err_bits_o    (err_bits),
      .lock_o        (lock),
      .lock_lost_o   (lost),
      .err_cnt_o     (err_cnt),
      .word_cnt_o    (word_cnt)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic set_poly(input int sel);
      case (sel)
         0:       begin tap_n = 7;  tap_m = 6;  end
         1:       begin tap_n = 15; tap_m = 14; end
         2:       begin tap_n = 23; tap_m = 18; end
         default: begin tap_n = 31; tap_m = 28; end
      endcase
   endtask

   // serial reference generator, one bit at a time
   task automatic next_bit(output logic b);
      b    = hist[tap_n-1] ^ hist[tap_m-1];
      hist = {hist[62:0], b};
   endtask

   task automatic seed(input int phase);
      logic b;
      hist = 64'h1;
      for (int i = 0; i < phase; i++) next_bit(b);
   endtask

   task automatic next_word(output logic [DW-1:0] w);
      logic b;
      for (int i = 0; i < DW; i++) begin
         next_bit(b);
         w[i] = b;
      end
   endtask

   function automatic logic [DW-1:0] low_mask(input int k);
      logic [DW-1:0] m = '0;
      for (int i = 0; i < k; i++) m[i] = 1'b1;
      return m;
   endfunction

   task automatic drive(input logic [DW-1:0] w, input int nfl);
      logic was;
      int   tmp;
      was     = lock;
      rx_data = w;
      @(posedge clk);
      #1;
      if (was && !link_rst) begin
         if (exp_words != '1) exp_words = exp_words + 1'b1;
         tmp = int'(exp_errs) + nfl;
         exp_errs = (tmp > 65535) ? '1 : CW'(tmp);
      end
   endtask

   task automatic do_reset(input int sel);
      rst_n    = 1'b0;
      link_rst = 1'b0;
      rx_data  = '0;
      pat_sel  = 2'(sel);
      repeat (3) @(posedge clk);
      #1;
      rst_n     = 1'b1;
      exp_words = '0;
      exp_errs  = '0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] w;
      int            sel;
      int            phase;
      int            nfl;
      int            guard;

      // R10: reset state
      rst_n    = 1'b0;
      link_rst = 1'b0;
      pat_sel  = 2'd0;
      rx_data  = '1;
      repeat (2) @(posedge clk);
      #1;
      check("R10", "lock in reset", lock, 0);
      check("R10", "lost in reset", lost, 0);
      check("R10", "flag in reset", err_flag, 0);
      check("R10", "bits in reset", err_bits, 0);
      check("R10", "word in reset", err_word, 0);
      check("R10", "err total in reset", err_cnt, 0);
      check("R10", "word total in reset", word_cnt, 0);

      // vector table: order, phase, injected flips
      for (int v = 0; v < 6; v++) begin
         sel   = int'(VECS[v][13:12]);
         phase = int'(VECS[v][11:6]);
         nfl   = int'(VECS[v][5:0]);
         do_reset(sel);
         set_poly(sel);
         seed(phase);
         for (int k = 1; k <= 17; k++) begin
            next_word(w);
            drive(w, 0);
            if (k == 16) check("R3", "no lock after 16th word", lock, 0);
            if (k == 17) begin
               check("R3", "lock after 17th word", lock, 1);
               check("R2", "clean at phase", err_flag, 0);
            end
         end
         next_word(w);
         drive(w ^ low_mask(nfl), nfl);
         check("R5", "error bit count", err_bits, nfl);
         check("R5", "error word", err_word, low_mask(nfl));
         check("R5", "error flag", err_flag, (nfl != 0));
         next_word(w);
         drive(w, 0);
         check("R4", "reference survives errors", err_flag, 0);
         check("R4", "still locked", lock, 1);
         check("R9", "word total", word_cnt, exp_words);
         check("R9", "error total", err_cnt, exp_errs);
      end

      // R1: wrong order selected never locks
      do_reset(1);
      set_poly(0);
      seed(4);
      for (int k = 0; k < 40; k++) begin
         next_word(w);
         drive(w, 0);
      end
      check("R1", "mismatched order lock", lock, 0);
      check("R1", "mismatched order flag", err_flag, 1);
      check("R9", "no words counted while hunting", word_cnt, 0);

      // R8: select change ignored while tracking
      do_reset(2);
      set_poly(2);
      seed(9);
      for (int k = 0; k < 17; k++) begin
         next_word(w);
         drive(w, 0);
      end
      pat_sel = 2'd0;
      guard = 0;
      for (int k = 0; k < 6; k++) begin
         next_word(w);
         drive(w, 0);
         if (err_flag) guard++;
      end
      check("R8", "errors after select change", guard, 0);
      check("R8", "lock after select change", lock, 1);
      pat_sel = 2'd2;

      // R6: loss of tracking with 10/11-bit threshold
      for (int k = 0; k < 7; k++) begin
         next_word(w);
         drive(w ^ low_mask(11), 11);
      end
      next_word(w);
      drive(w ^ low_mask(10), 10);
      check("R6", "10-bit word keeps lock", lock, 1);
      check("R6", "no lost pulse yet", lost, 0);
      for (int k = 0; k < 7; k++) begin
         next_word(w);
         drive(w ^ low_mask(11), 11);
      end
      check("R6", "7 bad words keep lock", lock, 1);
      next_word(w);
      drive(w ^ low_mask(11), 11);
      check("R6", "8th bad word drops lock", lock, 0);
      check("R6", "lost pulse", lost, 1);
      next_word(w);
      drive(w, 0);
      check("R6", "lost pulse ends", lost, 0);

      // R7: link reset, totals held, reseeded from presented word
      for (int k = 0; k < 20; k++) begin
         next_word(w);
         drive(w, 0);
      end
      check("R7", "relocked before link reset", lock, 1);
      link_rst = 1'b1;
      next_word(w);
      drive(w, 0);
      link_rst = 1'b0;
      check("R7", "link reset unlocks", lock, 0);
      check("R7", "word total held", word_cnt, exp_words);
      check("R7", "error total held", err_cnt, exp_errs);
      for (int k = 1; k <= 16; k++) begin
         next_word(w);
         drive(w, 0);
         if (k == 15) check("R7", "no lock after 15 words", lock, 0);
         if (k == 16) check("R7", "lock after 16 words", lock, 1);
      end

      // R9: error total saturation
      guard = 0;
      while (exp_errs != '1 && guard < 1000) begin
         for (int k = 0; k < 7; k++) begin
            next_word(w);
            drive(~w, 40);
         end
         next_word(w);
         drive(w, 0);
         guard++;
      end
      check("R9", "error total saturated", err_cnt, 16'hFFFF);
      check("R9", "word total tracked", word_cnt, exp_words);
      next_word(w);
      drive(~w, 40);
      check("R9", "saturated total holds", err_cnt, 16'hFFFF);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule